// File: doc/BRIEF.md
# I2S Slave Audio Serial Port

This block is the slave side of a two-channel I2S audio link. An external master supplies the bit clock and the word-select (frame sync) line. The port shifts one transmit word out and one receive word in during each half of a frame. All pins are brought into the system clock domain through synchronizers. Every rise or fall of word select opens a new slot. Word select is treated as one bit early: the first data bit comes on the bit clock after the transition. Word select low means the left channel and high means the right channel.

A programmable word-length code sets how many bits are moved per slot. When those bits are done, the port idles until the next word-select transition, so the master's slot may be longer than the word. On the parallel side, each direction has a valid/ready word interface. Words are right-justified at bit 0. Each received word is tagged with its channel. Two sticky flags record a transmit underrun and a receive overrun.

Top module: `i2s_slave_port`

## Requirements
- R1: After reset, sdout is 0, rx_valid is 0, tx_ready is 1, and both tx_underrun and rx_overrun are 0. No slot begins until a word-select transition has been seen on a bit-clock rise after reset.
- R2: The wl_code input picks the word length W. Code 0 gives 8, 1 gives 16, 2 gives 18, 3 gives 20, 4 gives 22 and 5 gives 24 bits. Codes 6 and 7 give 24. A received word sits in rx_data[W-1:0], and the bits above are 0.
- R3: Both edges of ws start a slot. The receive bits are sampled on bit-clock rises, MSB first, starting with the first rise after the rise on which the new ws level is first seen. rx_chan carries the ws level of that slot: 0 is left, 1 is right.
- R4: A word is accepted when tx_valid and tx_ready are both 1 at a clock edge. tx_ready is 0 while a word is held. At slot start the held word is loaded, and bits W-1 down to 0 are driven on sdout on successive bit-clock falls, MSB first. Bits above W-1 are ignored.
- R5: Once W bits have been moved in a slot, further bit clocks in that slot are ignored. sdout is 0, and sdin data does not reach rx_data.
- R6: If no word is held at slot start, sdout is 0 for the whole slot and tx_underrun is set. The flag stays set until reset.
- R7: If a received word completes while the previous one is still valid and not taken, rx_overrun is set and stays set until reset. The newest word replaces the old one, and rx_valid stays 1 until the word is taken.
- R8: wl_code is captured at slot start. A change in the middle of a slot takes effect from the next slot.
- R9: A slot shorter than W bits is cut off by the next ws transition. Its partial receive word is discarded without asserting rx_valid. Transmission restarts with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wl_code | input | 3 | Word-length code |
| bclk | input | 1 | Bit clock from the master |
| ws | input | 1 | Word select from the master, low = left |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| tx_data | input | MAX_W | Transmit word, right-justified |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Port can take a transmit word |
| rx_data | output | MAX_W | Received word, right-justified |
| rx_chan | output | 1 | Channel of the received word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| tx_underrun | output | 1 | Sticky: a slot started with no transmit word |
| rx_overrun | output | 1 | Sticky: a received word was overwritten |

## Verification
Several stream shapes exercise the slot engine:
- **Slots exactly W bits long** force a word's last bit and the next slot's start onto the same bit-clock rise.
- **Long slots with ones on sdin after the word** show whether extra clocks leak into rx_data or sdout.
- **A sweep of every wl_code value** tells a correct width decode from an off-by-one count.
- **A slot cut short** separates restart-on-transition from counting to W.
- **A word-length change in mid-slot** shows when the length is captured.
- **Runs with no transmit words, and with the receive side stalled,** expose the underrun and overrun paths.

// File: rtl/i2s_slave_pkg.sv
package i2s_slave_pkg;

  typedef enum logic [2:0] {
    WLEN_8  = 3'd0,
    WLEN_16 = 3'd1,
    WLEN_18 = 3'd2,
    WLEN_20 = 3'd3,
    WLEN_22 = 3'd4,
    WLEN_24 = 3'd5
  } wlen_code_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic ws;
    logic sd;
  } pin_evt_t;

  function automatic logic [5:0] word_bits(input logic [2:0] code);
    case (code)
      WLEN_8:  word_bits = 6'd8;
      WLEN_16: word_bits = 6'd16;
      WLEN_18: word_bits = 6'd18;
      WLEN_20: word_bits = 6'd20;
      WLEN_22: word_bits = 6'd22;
      default: word_bits = 6'd24;
    endcase
  endfunction

endpackage

// File: rtl/i2s_pin_sync.sv
module i2s_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bclk_i,
  input  logic                    ws_i,
  input  logic                    sd_i,
  output i2s_slave_pkg::pin_evt_t evt_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][2:0] chain;
  logic                   bclk_q;
  logic [2:0]             raw;

  assign raw = {bclk_i, ws_i, sd_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      bclk_q <= 1'b0;
      evt_o  <= '0;
    end else begin
      chain[0] <= raw;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      bclk_q     <= chain[LAST][2];
      evt_o.rise <= chain[LAST][2] & ~bclk_q;
      evt_o.fall <= ~chain[LAST][2] & bclk_q;
      evt_o.ws   <= chain[LAST][1];
      evt_o.sd   <= chain[LAST][0];
    end
  end
endmodule

// File: rtl/i2s_slot_tracker.sv
module i2s_slot_tracker #(
  parameter int MAX_W = 24,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             ws_lvl,
  input  logic [2:0]       wl_code,
  output logic             slot_start,
  output logic [CNT_W-1:0] cur_bits,
  output logic             cur_chan
);
  logic       primed;
  logic       ws_prev;
  logic [5:0] req_bits;

  assign req_bits   = i2s_slave_pkg::word_bits(wl_code);
  assign slot_start = rise && primed && (ws_lvl != ws_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed   <= 1'b0;
      ws_prev  <= 1'b0;
      cur_bits <= CNT_W'(8);
      cur_chan <= 1'b0;
    end else if (rise) begin
      primed  <= 1'b1;
      ws_prev <= ws_lvl;
      if (slot_start) begin
        cur_bits <= (int'(req_bits) > MAX_W) ? CNT_W'(MAX_W) : CNT_W'(req_bits);
        cur_chan <= ws_lvl;
      end
    end
  end
endmodule

// File: rtl/i2s_rx_shifter.sv
module i2s_rx_shifter #(
  parameter int MAX_W = 24,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             sd,
  input  logic             slot_start,
  input  logic [CNT_W-1:0] cur_bits,
  input  logic             cur_chan,
  input  logic             rx_ready,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_chan,
  output logic             rx_valid,
  output logic             rx_overrun
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [MAX_W-1:0] shreg;
  logic [MAX_W-1:0] next_sh;

  assign next_sh = {shreg[MAX_W-2:0], sd};

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      rx_data    <= '0;
      rx_chan    <= 1'b0;
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (rise && active) begin
        shreg <= next_sh;
        cnt   <= cnt + ONE;
        if (cnt == cur_bits - ONE) begin
          active   <= 1'b0;
          rx_data  <= next_sh;
          rx_chan  <= cur_chan;
          rx_valid <= 1'b1;
          if (rx_valid && !rx_ready) rx_overrun <= 1'b1;
        end
      end
      if (slot_start) begin
        active <= 1'b1;
        cnt    <= '0;
        shreg  <= '0;
      end
    end
  end
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
  parameter int MAX_W = 24,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall,
  input  logic             slot_start,
  input  logic [CNT_W-1:0] cur_bits,
  input  logic [MAX_W-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             sdout,
  output logic             tx_underrun
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [MAX_W-1:0] hold_q;
  logic             hold_full;
  logic [MAX_W-1:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic             active;

  assign tx_ready = ~hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      hold_full   <= 1'b0;
      shreg       <= '0;
      cnt         <= '0;
      active      <= 1'b0;
      sdout       <= 1'b0;
      tx_underrun <= 1'b0;
    end else begin
      if (tx_valid && !hold_full) begin
        hold_q    <= tx_data;
        hold_full <= 1'b1;
      end
      if (fall) begin
        if (active) begin
          sdout <= shreg[cur_bits - ONE];
          shreg <= shreg << 1;
          cnt   <= cnt + ONE;
          if (cnt == cur_bits - ONE) active <= 1'b0;
        end else begin
          sdout <= 1'b0;
        end
      end
      if (slot_start) begin
        active <= 1'b1;
        cnt    <= '0;
        if (hold_full) begin
          shreg     <= hold_q;
          hold_full <= 1'b0;
        end else begin
          shreg       <= '0;
          tx_underrun <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2s_slave_port.sv
module i2s_slave_port #(
  parameter int MAX_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       wl_code,
  input  logic             bclk,
  input  logic             ws,
  input  logic             sdin,
  output logic             sdout,
  input  logic [MAX_W-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_chan,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             tx_underrun,
  output logic             rx_overrun
);
  localparam int CNT_W = $clog2(MAX_W + 1);

  i2s_slave_pkg::pin_evt_t evt;
  logic                    slot_start;
  logic [CNT_W-1:0]        cur_bits;
  logic                    cur_chan;

  i2s_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk_i(bclk), .ws_i(ws), .sd_i(sdin), .evt_o(evt)
  );

  i2s_slot_tracker #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .rise(evt.rise), .ws_lvl(evt.ws), .wl_code(wl_code),
    .slot_start(slot_start), .cur_bits(cur_bits), .cur_chan(cur_chan)
  );

  i2s_rx_shifter #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .rise(evt.rise), .sd(evt.sd), .slot_start(slot_start),
    .cur_bits(cur_bits), .cur_chan(cur_chan), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_chan(rx_chan), .rx_valid(rx_valid), .rx_overrun(rx_overrun)
  );

  i2s_tx_shifter #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .fall(evt.fall), .slot_start(slot_start),
    .cur_bits(cur_bits), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .sdout(sdout), .tx_underrun(tx_underrun)
  );
endmodule

// File: rtl/i2s_slave_port_chk.sv
module i2s_slave_port_chk (
  input logic clk,
  input logic rst,
  input logic sdout,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic tx_underrun,
  input logic rx_overrun
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rx_valid && !tx_underrun && !rx_overrun && !sdout && tx_ready));

  assert_hold_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |=> tx_underrun);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |=> rx_overrun);

  assert_rx_waits_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> rx_valid);
endmodule

bind i2s_slave_port i2s_slave_port_chk u_chk (
  .clk(clk), .rst(rst), .sdout(sdout), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_underrun(tx_underrun),
  .rx_overrun(rx_overrun)
);

// File: tb/i2s_slave_port_bench.sv
module i2s_slave_port_bench;
  localparam int MW  = 24;
  localparam int PRE = 3;
  localparam int TRL = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    wl_code = 3'd1;
  logic          bclk = 1'b0, ws = 1'b0, sdin = 1'b0;
  logic          sdout;
  logic [MW-1:0] tx_data = '0;
  logic          tx_valid = 1'b0, tx_ready;
  logic [MW-1:0] rx_data;
  logic          rx_chan, rx_valid;
  logic          rx_ready = 1'b1;
  logic          tx_underrun, rx_overrun;

  always #5 clk = ~clk;

  i2s_slave_port u_i2s_slave_port (
    .clk(clk), .rst(rst), .wl_code(wl_code), .bclk(bclk), .ws(ws), .sdin(sdin),
    .sdout(sdout), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_chan(rx_chan), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int            nslot;
  bit            sl_lvl [16];
  int            sl_len [16];
  int            sl_w   [16];
  logic [MW-1:0] sl_rx  [16];
  logic [MW-1:0] sl_tx  [16];
  bit            feed_on;
  int            chg_at;
  logic [2:0]    chg_code;
  int            ncyc;
  bit            ws_a [1024];
  bit            sd_a [1024];
  bit            exp_a[1024];
  bit            cap_a[1024];

  logic [MW-1:0] got_d [64];
  bit            got_c [64];
  int            got_n;

  always @(negedge clk) begin
    if (!rst && rx_valid && rx_ready && got_n < 64) begin
      got_d[got_n] = rx_data;
      got_c[got_n] = rx_chan;
      got_n = got_n + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] lowmask(int w);
    logic [31:0] m;
    m = (32'h1 << w) - 32'h1;
    return m[MW-1:0];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bclk = 1'b0; ws = 1'b0; sdin = 1'b0; tx_valid = 1'b0; rx_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    got_n = 0;
    feed_on = 1'b1;
    chg_at = -1;
    chg_code = 3'd0;
    @(negedge clk);
  endtask

  function automatic int slot_of(int j, int starts[16]);
    if (j < PRE) return -1;
    for (int k = 0; k < nslot; k++)
      if (j >= starts[k] && j < starts[k] + sl_len[k]) return k;
    return nslot;
  endfunction

  task automatic build();
    int starts[16];
    int s;
    s = PRE;
    for (int k = 0; k < nslot; k++) begin
      starts[k] = s;
      s += sl_len[k];
    end
    ncyc = s + TRL;
    for (int j = 0; j < ncyc; j++) begin
      int k, kn, i;
      k  = slot_of(j, starts);
      kn = slot_of(j + 1, starts);
      ws_a[j] = (kn < 0) ? ~sl_lvl[0] : (kn >= nslot) ? sl_lvl[nslot-1] : sl_lvl[kn];
      sd_a[j] = (j % 3) != 1;
      exp_a[j] = 1'b0;
      if (k >= 0 && k < nslot) begin
        i = j - starts[k];
        if (i < sl_w[k]) sd_a[j] = sl_rx[k][sl_w[k]-1-i];
        if (feed_on && i < sl_w[k]) exp_a[j] = sl_tx[k][sl_w[k]-1-i];
      end
    end
  endtask

  task automatic run_stream();
    fork
      begin
        if (feed_on) begin
          for (int k = 0; k < nslot; k++) begin
            @(negedge clk);
            tx_valid = 1'b1;
            tx_data  = sl_tx[k];
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
          end
        end
      end
      begin
        for (int j = 0; j < ncyc; j++) begin
          @(negedge clk);
          bclk = 1'b0; ws = ws_a[j]; sdin = sd_a[j];
          if (j == chg_at) wl_code = chg_code;
          repeat (7) @(negedge clk);
          cap_a[j] = sdout;
          @(negedge clk);
          bclk = 1'b1;
          repeat (7) @(negedge clk);
        end
      end
    join
    repeat (20) @(negedge clk);
  endtask

  task automatic check_tx(string tag);
    int bad;
    bad = 0;
    for (int j = 0; j < ncyc; j++)
      if (cap_a[j] !== exp_a[j]) begin
        if (bad == 0) chk(tag, {31'd0, cap_a[j]}, {31'd0, exp_a[j]}, $sformatf("sdout cycle %0d", j));
        bad++;
      end
    if (bad == 0) chk(tag, 32'd0, 32'd0, "sdout stream");
  endtask

  task automatic check_rx(string tag);
    int n;
    n = 0;
    for (int k = 0; k < nslot; k++)
      if (sl_len[k] >= sl_w[k]) begin
        if (n < got_n) begin
          chk(tag, {8'd0, got_d[n]}, {8'd0, sl_rx[k] & lowmask(sl_w[k])}, $sformatf("rx word slot %0d", k));
          chk(tag, {31'd0, got_c[n]}, {31'd0, sl_lvl[k]}, $sformatf("rx chan slot %0d", k));
        end
        n++;
      end
    chk(tag, got_n, n, "rx word count");
  endtask

  task automatic test_reset();
    do_reset();
    chk("R1", {31'd0, sdout}, 32'd0, "sdout after reset");
    chk("R1", {31'd0, rx_valid}, 32'd0, "rx_valid after reset");
    chk("R1", {31'd0, tx_ready}, 32'd1, "tx_ready after reset");
    chk("R1", {30'd0, tx_underrun, rx_overrun}, 32'd0, "flags after reset");
  endtask

  task automatic test_exact_slots();
    do_reset();
    wl_code = 3'd1;
    nslot = 4;
    for (int k = 0; k < 4; k++) begin
      sl_lvl[k] = k[0]; sl_len[k] = 16; sl_w[k] = 16;
    end
    sl_rx[0] = 24'h00A5C3; sl_rx[1] = 24'h00F00F; sl_rx[2] = 24'h008001; sl_rx[3] = 24'h007FFE;
    sl_tx[0] = 24'hFF1234; sl_tx[1] = 24'h00BEEF; sl_tx[2] = 24'h5A8421; sl_tx[3] = 24'h000001;
    build();
    run_stream();
    check_rx("R3");
    check_tx("R4");
    chk("R6", {31'd0, tx_underrun}, 32'd0, "no underrun when fed");
  endtask

  task automatic test_long_slots();
    do_reset();
    wl_code = 3'd5;
    nslot = 3;
    for (int k = 0; k < 3; k++) begin
      sl_lvl[k] = ~k[0]; sl_len[k] = 32; sl_w[k] = 24;
    end
    sl_rx[0] = 24'hC0FFEE; sl_rx[1] = 24'h123456; sl_rx[2] = 24'h800001;
    sl_tx[0] = 24'hABCDEF; sl_tx[1] = 24'h000F00; sl_tx[2] = 24'hFFFFFF;
    build();
    run_stream();
    check_rx("R5");
    check_tx("R5");
  endtask

  task automatic test_codes();
    for (int c = 0; c < 7; c++) begin
      logic [2:0] code;
      int w;
      code = (c < 6) ? 3'(c) : 3'd7;
      case (c)
        0: w = 8; 1: w = 16; 2: w = 18; 3: w = 20; 4: w = 22; default: w = 24;
      endcase
      do_reset();
      wl_code = code;
      nslot = 2;
      for (int k = 0; k < 2; k++) begin
        sl_lvl[k] = k[0]; sl_len[k] = 26; sl_w[k] = w;
      end
      sl_rx[0] = 24'hFFFFFF; sl_rx[1] = 24'h9B5D31;
      sl_tx[0] = 24'hFFFFFF; sl_tx[1] = 24'h6C3A97;
      build();
      run_stream();
      check_rx("R2");
      check_tx("R2");
    end
  endtask

  task automatic test_underrun();
    do_reset();
    wl_code = 3'd0;
    feed_on = 1'b0;
    nslot = 2;
    for (int k = 0; k < 2; k++) begin
      sl_lvl[k] = k[0]; sl_len[k] = 12; sl_w[k] = 8;
    end
    sl_rx[0] = 24'h0000C6; sl_rx[1] = 24'h000039;
    sl_tx[0] = 24'h0000FF; sl_tx[1] = 24'h0000FF;
    build();
    run_stream();
    check_tx("R6");
    chk("R6", {31'd0, tx_underrun}, 32'd1, "underrun flag set");
    repeat (30) @(negedge clk);
    chk("R6", {31'd0, tx_underrun}, 32'd1, "underrun flag sticky");
  endtask

  task automatic test_overrun();
    do_reset();
    wl_code = 3'd1;
    rx_ready = 1'b0;
    nslot = 2;
    for (int k = 0; k < 2; k++) begin
      sl_lvl[k] = k[0]; sl_len[k] = 16; sl_w[k] = 16;
    end
    sl_rx[0] = 24'h001111; sl_rx[1] = 24'h00E2E2;
    sl_tx[0] = 24'h0; sl_tx[1] = 24'h0;
    build();
    run_stream();
    chk("R7", got_n, 0, "no handshake while stalled");
    chk("R7", {31'd0, rx_overrun}, 32'd1, "overrun flag");
    chk("R7", {31'd0, rx_valid}, 32'd1, "rx_valid held");
    chk("R7", {8'd0, rx_data}, 32'h0000E2E2, "newest word kept");
    chk("R7", {31'd0, rx_chan}, 32'd1, "newest word chan");
    rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7", {31'd0, rx_valid}, 32'd0, "rx_valid cleared after take");
    chk("R7", {31'd0, rx_overrun}, 32'd1, "overrun sticky");
  endtask

  task automatic test_wl_change();
    do_reset();
    wl_code = 3'd1;
    nslot = 3;
    for (int k = 0; k < 3; k++) begin
      sl_lvl[k] = k[0]; sl_len[k] = 16;
    end
    sl_w[0] = 16; sl_w[1] = 8; sl_w[2] = 8;
    chg_at = PRE + 4;
    chg_code = 3'd0;
    sl_rx[0] = 24'h00B00B; sl_rx[1] = 24'h0000A7; sl_rx[2] = 24'h00005E;
    sl_tx[0] = 24'h00D1CE; sl_tx[1] = 24'h0000C3; sl_tx[2] = 24'h00003C;
    build();
    run_stream();
    check_rx("R8");
    check_tx("R8");
  endtask

  task automatic test_short_slot();
    do_reset();
    wl_code = 3'd1;
    nslot = 3;
    sl_len[0] = 10; sl_len[1] = 16; sl_len[2] = 16;
    for (int k = 0; k < 3; k++) begin
      sl_lvl[k] = ~k[0]; sl_w[k] = 16;
    end
    sl_rx[0] = 24'h00FFFF; sl_rx[1] = 24'h004321; sl_rx[2] = 24'h00ACE1;
    sl_tx[0] = 24'h00F0F0; sl_tx[1] = 24'h001357; sl_tx[2] = 24'h00ABCD;
    build();
    run_stream();
    check_rx("R9");
    check_tx("R9");
  endtask

  initial begin
    test_reset();
    test_exact_slots();
    test_long_slots();
    test_codes();
    test_underrun();
    test_overrun();
    test_wl_change();
    test_short_slot();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule